// File: doc/BRIEF.md
# Two-Master Buffered Copy Engine

This block copies a programmed number of words from a source to a destination. A CPU sets it up through a small register port. The engine then asks for the system bus with a hold request and waits for the grant. Once it has the bus, a read master fetches words and pushes them into a small internal FIFO, while a separate write master drains that FIFO toward the destination. Either side can be set to a fixed address, which suits a peripheral data register, or to a word address that steps by one per transfer, which suits a memory range. This gives memory-to-peripheral, peripheral-to-memory and memory-to-memory copies.

A transfer normally ends when the programmed count of words has been written. In packet mode the source peripheral can end it sooner by flagging the last word it returns. At the end the engine raises an interrupt and drops its bus request. Writing the status register clears the interrupt.

Both master sides use valid/ready handshakes. A word moves on a rising edge where valid and ready are both high. Once valid is raised, it stays high and the address and data stay unchanged until ready is seen. The slave may hold ready low for as long as it needs. The grant must stay high until the engine drops `bus_hold`.

Top module: `dma_mover`

## Requirements
- R1: Register word indices are 0 source address, 1 destination address, 2 length in words, 3 control and 4 status. Control bit 0 is start, bit 1 holds the source address fixed, bit 2 holds the destination address fixed, and bit 3 selects packet mode. Status bit 0 is busy and bit 1 is done. Registers 0 to 3 read back what was written, except that start always reads as 0.
- R2: Writing control with start set while idle raises `bus_hold` on the next cycle. No read or write is offered while the grant is low, and the first read is offered in the cycle after the grant is first sampled high.
- R3: While busy, writes to registers 0 to 3 are ignored, including a second start.
- R4: Read k (counting from 0) uses the source address, plus k when the source is not fixed. Write k uses the destination address in the same way.
- R5: Valid, address and data on each master stay stable until ready. No read is offered while the 4-entry FIFO holds 4 words, and no write is offered while it is empty.
- R6: The words written are the words read, in the same order.
- R7: Completion counts words written. One cycle after the edge that completes the last write, `irq` is 1, `bus_hold` is 0, busy is 0 and done is 1.
- R8: In packet mode, a read accepted with `rd_eop` high is the last read. The transfer then completes once every word read so far has been written. If the programmed length is reached first, the transfer ends there.
- R9: Any write to the status register clears done and `irq`.
- R10: A length of 0 completes two cycles after the grant is first sampled high, with no read or write.
- R11: Busy and done are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_wr | input | 1 | register write strobe |
| cfg_addr | input | 3 | register word index |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data, combinational from `cfg_addr` |
| bus_hold | output | 1 | bus ownership request |
| bus_grant | input | 1 | bus ownership granted |
| irq | output | 1 | completion interrupt |
| rd_valid | output | 1 | read request offered |
| rd_ready | input | 1 | read accepted; `rd_data` and `rd_eop` are valid in the same cycle |
| rd_addr | output | 32 | read word address |
| rd_data | input | 32 | read data |
| rd_eop | input | 1 | last word of the packet |
| wr_valid | output | 1 | write offered |
| wr_ready | input | 1 | write accepted |
| wr_addr | output | 32 | write word address |
| wr_data | output | 32 | write data |

## Verification
The bench drives every input just after a falling edge and reads outputs 1 ns later. Every result therefore belongs to a known rising edge.

Timing checked:
- **Bus request (R2):** `bus_hold` is checked in the cycle after the start write.
- **First read (R2):** `rd_valid` is checked exactly one cycle after the grant is raised.
- **Interrupt (R7):** the bench logs each write handshake in the half-cycle before the edge that completes it, and expects `irq` two falling edges after that log, which is one clock after the edge.
- **Zero length (R10):** the interrupt is expected two cycles after the grant.

FIFO back-pressure (R5) is checked by holding the write side stalled for a dozen cycles and then counting the reads accepted.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int REG_SRC = 0;
  localparam int REG_DST = 1;
  localparam int REG_LEN = 2;
  localparam int REG_CTL = 3;
  localparam int REG_STA = 4;

  localparam int CTL_GO   = 0;
  localparam int CTL_SFIX = 1;
  localparam int CTL_DFIX = 2;
  localparam int CTL_PKT  = 3;

  localparam int STA_BUSY = 0;
  localparam int STA_DONE = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_RUN} dma_state_e;
endpackage

// File: rtl/dma_ctl.sv
`timescale 1ns/1ps
module dma_ctl
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  input  logic           bus_grant,
  input  logic           finish,
  output logic [AW-1:0]  src,
  output logic [AW-1:0]  dst,
  output logic [LW-1:0]  len,
  output logic           sfix,
  output logic           dfix,
  output logic           pkt,
  output logic           run,
  output logic           busy,
  output logic           done,
  output logic           irq
);
  dma_state_e state;
  logic idle;

  assign idle = (state == ST_IDLE);
  assign run  = (state == ST_RUN);
  assign busy = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      src   <= '0;
      dst   <= '0;
      len   <= '0;
      sfix  <= 1'b0;
      dfix  <= 1'b0;
      pkt   <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: if (bus_grant) state <= ST_RUN;
        ST_RUN: if (finish) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          irq   <= 1'b1;
        end
        default: ;
      endcase
      if (cfg_wr) begin
        if (cfg_addr == RAW'(REG_STA)) begin
          done <= 1'b0;
          irq  <= 1'b0;
        end else if (idle) begin
          case (cfg_addr)
            RAW'(REG_SRC): src <= cfg_wdata;
            RAW'(REG_DST): dst <= cfg_wdata;
            RAW'(REG_LEN): len <= cfg_wdata[LW-1:0];
            RAW'(REG_CTL): begin
              sfix <= cfg_wdata[CTL_SFIX];
              dfix <= cfg_wdata[CTL_DFIX];
              pkt  <= cfg_wdata[CTL_PKT];
              if (cfg_wdata[CTL_GO]) begin
                state <= ST_HOLD;
                done  <= 1'b0;
                irq   <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RAW'(REG_SRC): cfg_rdata = src;
      RAW'(REG_DST): cfg_rdata = dst;
      RAW'(REG_LEN): cfg_rdata[LW-1:0] = len;
      RAW'(REG_CTL): begin
        cfg_rdata[CTL_SFIX] = sfix;
        cfg_rdata[CTL_DFIX] = dfix;
        cfg_rdata[CTL_PKT]  = pkt;
      end
      RAW'(REG_STA): begin
        cfg_rdata[STA_BUSY] = busy;
        cfg_rdata[STA_DONE] = done;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_fifo.sv
`timescale 1ns/1ps
module dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_rd.sv
`timescale 1ns/1ps
module dma_rd #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] src,
  input  logic          sfix,
  input  logic [LW-1:0] len,
  input  logic          pkt,
  input  logic          fifo_full,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_eop,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic [LW-1:0] rd_cnt,
  output logic          eop_seen
);
  assign rd_valid  = run && (rd_cnt < len) && !eop_seen && !fifo_full;
  assign rd_addr   = sfix ? src : src + AW'(rd_cnt);
  assign push      = rd_valid && rd_ready;
  assign push_data = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      eop_seen <= 1'b0;
    end else if (!run) begin
      rd_cnt   <= '0;
      eop_seen <= 1'b0;
    end else if (push) begin
      rd_cnt <= rd_cnt + LW'(1);
      if (pkt && rd_eop) eop_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_wr.sv
`timescale 1ns/1ps
module dma_wr #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] dst,
  input  logic          dfix,
  input  logic          fifo_empty,
  input  logic [DW-1:0] head,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          pop,
  output logic [LW-1:0] wr_cnt
);
  assign wr_valid = run && !fifo_empty;
  assign wr_addr  = dfix ? dst : dst + AW'(wr_cnt);
  assign wr_data  = head;
  assign pop      = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_cnt <= '0;
    else if (!run)   wr_cnt <= '0;
    else if (pop)    wr_cnt <= wr_cnt + LW'(1);
  end
endmodule

// File: rtl/dma_mover.sv
`timescale 1ns/1ps
module dma_mover #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          bus_hold,
  input  logic          bus_grant,
  output logic          irq,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_eop,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [AW-1:0] src, dst;
  logic [LW-1:0] len, rd_cnt, wr_cnt;
  logic sfix, dfix, pkt, run, busy, done, finish, eop_seen;
  logic push, pop, fifo_full, fifo_empty;
  logic [DW-1:0] push_data, head;

  assign finish   = run && ((wr_cnt == len) || (eop_seen && (wr_cnt == rd_cnt)));
  assign bus_hold = busy;

  dma_ctl #(.AW(AW), .LW(LW), .RAW(3)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_grant(bus_grant),
    .finish(finish), .src(src), .dst(dst), .len(len), .sfix(sfix),
    .dfix(dfix), .pkt(pkt), .run(run), .busy(busy), .done(done), .irq(irq)
  );

  dma_rd #(.AW(AW), .DW(DW), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .run(run), .src(src), .sfix(sfix), .len(len),
    .pkt(pkt), .fifo_full(fifo_full), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_eop(rd_eop), .push(push),
    .push_data(push_data), .rd_cnt(rd_cnt), .eop_seen(eop_seen)
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .pop(pop),
    .dout(head), .full(fifo_full), .empty(fifo_empty)
  );

  dma_wr #(.AW(AW), .DW(DW), .LW(LW)) u_wr (
    .clk(clk), .rst_n(rst_n), .run(run), .dst(dst), .dfix(dfix),
    .fifo_empty(fifo_empty), .head(head), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .pop(pop),
    .wr_cnt(wr_cnt)
  );
endmodule

// File: rtl/dma_mover_chk.sv
`timescale 1ns/1ps
module dma_mover_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_hold,
  input logic          irq,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          busy,
  input logic          done
);
  // R2
  access_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_valid) |-> bus_hold);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rd_valid);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !wr_valid);

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!bus_hold && done));

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind dma_mover dma_mover_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_hold(bus_hold), .irq(irq),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .busy(busy), .done(done)
);

// File: tb/sim_dma_mover.sv
`timescale 1ns/1ps
module sim_dma_mover;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_grant = 1'b0;
  logic        bus_hold, irq, rd_valid, wr_valid;
  logic        rd_ready = 1'b0, wr_ready = 1'b0, rd_eop = 1'b0;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rd_data = '0;

  dma_mover u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_hold(bus_hold),
    .bus_grant(bus_grant), .irq(irq), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_eop(rd_eop), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [31:0] smem [64];
  logic [31:0] rlog_a [256];
  logic [31:0] wlog_a [256];
  logic [31:0] wlog_d [256];
  int cyc = 0, n_rd = 0, n_wr = 0, last_wr_cyc = 0;
  int rd_base = 0, wr_base = 0, eop_idx = 0, grant_cyc = 0;
  logic [7:0] rd_pat = 8'hFF, wr_pat = 8'hFF;
  bit pkt_on = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] e_src, e_dst;
  bit e_sfix, e_dfix;
  int e_n;

  initial for (int i = 0; i < 64; i++) smem[i] = 32'h5A00_0000 | (i * 32'h0000_0101);

  // slave models: drive after the falling edge, log handshakes due at the next rising edge
  always @(negedge clk) begin
    int seq;
    cyc = cyc + 1;
    rd_ready = rd_pat[cyc & 7];
    wr_ready = wr_pat[cyc & 7];
    seq = n_rd - rd_base;
    rd_data = smem[rd_addr[5:0]] ^ 32'(seq);
    rd_eop = pkt_on && (seq == eop_idx);
    if (rd_valid && rd_ready) begin
      rlog_a[n_rd & 255] = rd_addr;
      n_rd = n_rd + 1;
    end
    if (wr_valid && wr_ready) begin
      wlog_a[n_wr & 255] = wr_addr;
      wlog_d[n_wr & 255] = wr_data;
      last_wr_cyc = cyc;
      n_wr = n_wr + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic xfer_start(input logic [31:0] src, input logic [31:0] dst, input int len,
                            input bit sfix, input bit dfix, input bit pkt, input int eop,
                            input logic [7:0] rp, input logic [7:0] wp, input int gdly);
    rd_pat = rp; wr_pat = wp; pkt_on = pkt; eop_idx = eop;
    rd_base = n_rd; wr_base = n_wr;
    e_src = src; e_dst = dst; e_sfix = sfix; e_dfix = dfix;
    e_n = (pkt && (eop + 1 < len)) ? eop + 1 : len;
    cfg_write(3'd0, src);
    cfg_write(3'd1, dst);
    cfg_write(3'd2, 32'(len));
    cfg_write(3'd3, {28'd0, pkt, dfix, sfix, 1'b1});
    repeat (gdly) @(negedge clk);
    #1;
    chk("R2 hold raised before grant", {31'd0, bus_hold}, 32'd1);
    chk("R2 no read before grant", {31'd0, rd_valid}, 32'd0);
    chk("R2 no write before grant", {31'd0, wr_valid}, 32'd0);
    @(negedge clk);
    bus_grant = 1'b1;
    #1 grant_cyc = cyc;
    @(negedge clk);
    #1;
    chk("R2 first read one cycle after grant", {31'd0, rd_valid}, {31'd0, len > 0});
  endtask

  task automatic xfer_finish(input string tag);
    int irq_cyc;
    logic [31:0] v, ra;
    irq_cyc = -1;
    for (int t = 0; t < 2000; t++) begin
      if (irq) begin irq_cyc = cyc; break; end
      @(negedge clk);
      #1;
    end
    chk({tag, " R7 irq raised"}, {31'd0, irq}, 32'd1);
    chk({tag, " R7 bus released"}, {31'd0, bus_hold}, 32'd0);
    if (e_n > 0) chk({tag, " R7 irq one cycle after last write"}, 32'(irq_cyc), 32'(last_wr_cyc + 2));
    else         chk({tag, " R10 irq two cycles after grant"}, 32'(irq_cyc), 32'(grant_cyc + 2));
    chk({tag, " R8 read count"}, 32'(n_rd - rd_base), 32'(e_n));
    chk({tag, " R7 write count"}, 32'(n_wr - wr_base), 32'(e_n));
    for (int k = 0; k < e_n; k++) begin
      ra = e_sfix ? e_src : e_src + 32'(k);
      chk({tag, " R4 read address"}, rlog_a[(rd_base + k) & 255], ra);
      chk({tag, " R4 write address"}, wlog_a[(wr_base + k) & 255], e_dfix ? e_dst : e_dst + 32'(k));
      chk({tag, " R6 write data"}, wlog_d[(wr_base + k) & 255], smem[ra[5:0]] ^ 32'(k));
    end
    cfg_read(3'd4, v);
    chk({tag, " R11 status done not busy"}, v, 32'd2);
    cfg_write(3'd4, 32'd0);
    cfg_read(3'd4, v);
    chk({tag, " R9 status cleared"}, v, 32'd0);
    chk({tag, " R9 irq cleared"}, {31'd0, irq}, 32'd0);
    bus_grant = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R2 reset hold low", {31'd0, bus_hold}, 32'd0);
    chk("R7 reset irq low", {31'd0, irq}, 32'd0);
    chk("R5 reset no read", {31'd0, rd_valid}, 32'd0);
    chk("R5 reset no write", {31'd0, wr_valid}, 32'd0);
    cfg_read(3'd4, v);
    chk("R11 reset status", v, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    cfg_write(3'd0, 32'h1234_5678);
    cfg_write(3'd1, 32'h9ABC_DEF0);
    cfg_write(3'd2, 32'hFFFF_BEEF);
    cfg_write(3'd3, 32'h0000_000E);
    cfg_read(3'd0, v); chk("R1 source readback", v, 32'h1234_5678);
    cfg_read(3'd1, v); chk("R1 destination readback", v, 32'h9ABC_DEF0);
    cfg_read(3'd2, v); chk("R1 length readback", v, 32'h0000_BEEF);
    cfg_read(3'd3, v); chk("R1 control readback", v, 32'h0000_000E);
    cfg_read(3'd4, v); chk("R1 status idle", v, 32'd0);
    chk("R1 no start without go bit", {31'd0, bus_hold}, 32'd0);
  endtask

  task automatic t_mem2mem;
    xfer_start(32'd4, 32'h100, 6, 1'b0, 1'b0, 1'b0, 0, 8'hFF, 8'hFF, 3);
    xfer_finish("m2m");
  endtask

  task automatic t_mem2per;
    xfer_start(32'd10, 32'h8000_0040, 7, 1'b0, 1'b1, 1'b0, 0, 8'b1011_0111, 8'b0101_0011, 1);
    xfer_finish("m2p");
  endtask

  task automatic t_per2mem;
    xfer_start(32'h21, 32'h200, 5, 1'b1, 1'b0, 1'b0, 0, 8'h6D, 8'hFF, 2);
    xfer_finish("p2m");
  endtask

  task automatic t_busy_full;
    logic [31:0] v;
    xfer_start(32'd2, 32'h300, 9, 1'b0, 1'b0, 1'b0, 0, 8'hFF, 8'h00, 1);
    repeat (12) @(negedge clk);
    #1;
    chk("R5 reads stop at fifo depth", 32'(n_rd - rd_base), 32'(DEPTH));
    chk("R5 no read while full", {31'd0, rd_valid}, 32'd0);
    chk("R5 write offered while data held", {31'd0, wr_valid}, 32'd1);
    cfg_write(3'd0, 32'h3F);
    cfg_read(3'd0, v);
    chk("R3 source write ignored while busy", v, 32'd2);
    cfg_write(3'd3, 32'h0000_0003);
    cfg_read(3'd3, v);
    chk("R3 control write ignored while busy", v, 32'd0);
    wr_pat = 8'hFF;
    xfer_finish("busy");
  endtask

  task automatic t_packet;
    xfer_start(32'd40, 32'h400, 10, 1'b0, 1'b0, 1'b1, 3, 8'hFF, 8'hFF, 1);
    xfer_finish("R8 eop");
    xfer_start(32'd50, 32'h480, 3, 1'b0, 1'b0, 1'b1, 8, 8'hDD, 8'hFF, 1);
    xfer_finish("R8 length first");
  endtask

  task automatic t_zero;
    xfer_start(32'd0, 32'h500, 0, 1'b0, 1'b0, 1'b0, 0, 8'hFF, 8'hFF, 1);
    xfer_finish("R10 zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset;
    t_regs;
    t_mem2mem;
    t_mem2per;
    t_per2mem;
    t_busy_full;
    t_packet;
    t_zero;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule